// File: doc/BRIEF.md
# Serial ADC Responder with Power Modes

This block models the digital side of a three-wire serial analog-to-digital converter. A host drives a convert strobe and a serial clock. The block answers with a serial frame on a data pin that it drives only while a conversion is in progress. The parallel sample input stands in for the analog front end. A cycle counter stands in for the time the voltage reference needs to settle. The block is meant as a well-behaved responder for exercising host controllers in simulation or on a prototype.

All host pins are sampled on a fast system clock, and the block acts on their edges. A conversion starts on a convert rising edge. It is clocked out over sixteen serial-clock rising edges: first a ready flag, then the sample from its most significant bit down. Convert pulses given while the serial clock stays low choose a power mode. Two pulses select light sleep and four select deep sleep. The next serial-clock rising edge leaves either mode. After deep sleep the reference must settle again. Until it has, conversions return all zeros, and the ready flag reads zero as well.

Top module: `serial_adc_responder`

## Requirements
- R1: A convert rising edge in the active or settling state starts a conversion. Further convert edges have no effect on the frame until the conversion ends on its sixteenth counted serial-clock rising edge.
- R2: Counting only the serial-clock rising edges that are taken into account: edge 1 presents the ready flag on `sdo`, and edges 2 to 13 present sample bits 11 down to 0. Edges 14 and 15 present 0. `sdo_oe` is high from edge 1 through edge 15, and edge 16 drops it.
- R3: Whenever no conversion is in progress, `sdo_oe` is low and `sdo` is 0.
- R4: If the first serial-clock rising edge after a start arrives fewer than MIN_GAP system cycles after the start, it is skipped. The frame then begins one serial-clock edge later.
- R5: The sample input is captured when a conversion starts. Changes to it during the frame do not alter the bits shifted out.
- R6: With the serial clock low, the second counted convert falling edge enters light sleep and abandons any conversion in progress. Convert edges in either sleep mode start nothing.
- R7: With the serial clock low, the fourth counted convert falling edge enters deep sleep and clears the ready flag.
- R8: The convert-pulse count returns to zero on every serial-clock rising edge. Counts of 1 or 3 cause no mode change of their own.
- R9: A serial-clock rising edge in light sleep returns the block to the active state with the ready flag unchanged.
- R10: A serial-clock rising edge in deep sleep enters the settling state. The ready flag stays 0 for SETTLE_CYCLES system cycles, after which the block becomes active with the ready flag set.
- R11: A conversion started while the ready flag is 0 shifts out all zeros, the ready-flag position included.
- R12: After reset the block is active with the ready flag set, `sdo_oe` is low and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the host pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host |
| conv_in | input | 1 | Convert strobe from the host |
| smp_in | input | DATA_W | Parallel sample standing in for the analog value |
| sdo | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Output enable for the serial data pin |

## Verification
The assertions assume that `sclk_in` and `conv_in` are synchronous to `clk` and that each level is held for at least one system cycle. They also assume that the serial clock is low whenever a convert falling edge is meant to count as a power-mode pulse. Mid-frame, at most one convert pulse is expected between two serial-clock rising edges, so that a frame is never turned into a sleep request by accident. The bench changes every input on the falling edge of `clk` and holds each serial-clock phase for whole cycles. It gives at most one stray convert pulse inside a frame, so it stays within these assumptions.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_LIGHT  = 2'd1,
    PM_DEEP   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_mode_e;

  localparam int unsigned PULSE_W = 3;
  typedef logic [PULSE_W-1:0] pulse_cnt_t;

  localparam pulse_cnt_t LIGHT_PULSES = pulse_cnt_t'(2);
  localparam pulse_cnt_t DEEP_PULSES  = pulse_cnt_t'(4);

  // Saturating increment for the mode-select pulse counter.
  function automatic pulse_cnt_t pulse_bump(input pulse_cnt_t c);
    return (c == '1) ? c : c + pulse_cnt_t'(1);
  endfunction

  function automatic logic pulses_pick_light(input pulse_cnt_t c);
    return c == LIGHT_PULSES;
  endfunction

  function automatic logic pulses_pick_deep(input pulse_cnt_t c);
    return c == DEEP_PULSES;
  endfunction

  // Conversions may start only while awake (settled or settling).
  function automatic logic mode_accepts_start(input pm_mode_e m);
    return (m == PM_ACTIVE) || (m == PM_SETTLE);
  endfunction

endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  if (RISING) begin : g_rise
    assign edge_o = sig_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~sig_i & prev_q;
  end

endmodule

// File: rtl/sadc_power.sv
module sadc_power
  import sadc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 250000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_lvl_i,
  input  logic     sclk_rise_i,
  input  logic     conv_fall_i,
  output pm_mode_e mode_o,
  output logic     ready_o,
  output logic     sleep_evt_o
);

  localparam int unsigned SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYCLES - 1);

  pm_mode_e            mode_q, mode_d;
  logic                ready_q, ready_d;
  logic [SETTLE_W-1:0] settle_q, settle_d;
  pulse_cnt_t          pulse_q, pulse_d;

  // Named events for the checks below.
  logic counted_fall, light_hit, deep_hit, wake_evt, settle_done;

  assign counted_fall = conv_fall_i & ~sclk_lvl_i;
  assign light_hit    = counted_fall & pulses_pick_light(pulse_d);
  assign deep_hit     = counted_fall & pulses_pick_deep(pulse_d);
  assign wake_evt     = sclk_rise_i & ((mode_q == PM_LIGHT) | (mode_q == PM_DEEP));
  assign settle_done  = (mode_q == PM_SETTLE) & (settle_q == SETTLE_LAST);

  always_comb begin
    pulse_d = pulse_q;
    if (sclk_rise_i)       pulse_d = '0;
    else if (counted_fall) pulse_d = pulse_bump(pulse_q);
  end

  always_comb begin
    mode_d      = mode_q;
    ready_d     = ready_q;
    settle_d    = settle_q;
    sleep_evt_o = 1'b0;
    unique case (mode_q)
      PM_ACTIVE, PM_SETTLE: begin
        if (deep_hit) begin
          mode_d      = PM_DEEP;
          ready_d     = 1'b0;
          settle_d    = '0;
          sleep_evt_o = 1'b1;
        end else if (light_hit) begin
          mode_d      = PM_LIGHT;
          sleep_evt_o = 1'b1;
        end else if (settle_done) begin
          mode_d   = PM_ACTIVE;
          ready_d  = 1'b1;
          settle_d = '0;
        end else if (mode_q == PM_SETTLE) begin
          settle_d = settle_q + SETTLE_W'(1);
        end
      end
      PM_LIGHT: begin
        if (deep_hit) begin
          mode_d   = PM_DEEP;
          ready_d  = 1'b0;
          settle_d = '0;
        end else if (sclk_rise_i) begin
          mode_d = ready_q ? PM_ACTIVE : PM_SETTLE;
        end
      end
      PM_DEEP: begin
        if (sclk_rise_i) begin
          mode_d   = PM_SETTLE;
          settle_d = '0;
        end
      end
      default: mode_d = PM_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_ACTIVE;
      ready_q  <= 1'b1;
      settle_q <= '0;
      pulse_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      ready_q  <= ready_d;
      settle_q <= settle_d;
      pulse_q  <= pulse_d;
    end
  end

  assign mode_o  = mode_q;
  assign ready_o = ready_q;

  assert_pulse_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise_i |=> (pulse_q == '0));

  assert_odd_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_ACTIVE && sclk_rise_i) |=> (mode_q == PM_ACTIVE));

  assert_light_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_ACTIVE && counted_fall && pulse_q == pulse_cnt_t'(1)) |=> (mode_q == PM_LIGHT));

  assert_deep_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (counted_fall && pulse_q == pulse_cnt_t'(3)) |=> (mode_q == PM_DEEP && !ready_q));

  assert_light_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_LIGHT && sclk_rise_i && ready_q) |=> (mode_q == PM_ACTIVE && ready_q));

  assert_deep_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DEEP && sclk_rise_i) |=> (mode_q == PM_SETTLE && settle_q == '0));

  assert_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DEEP || mode_q == PM_SETTLE) |-> !ready_q);

  assert_settle_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SETTLE) |-> (settle_q <= SETTLE_LAST));

  assert_settle_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_done && !counted_fall) |=> (mode_q == PM_ACTIVE && ready_q));

endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CONV_CLKS = 16,
  parameter int unsigned MIN_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok_i,
  input  logic              ready_i,
  input  logic              conv_rise_i,
  input  logic              sclk_rise_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic              busy_o
);

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned RISE_W  = $clog2(CONV_CLKS + 1);
  localparam int unsigned GAP_W   = $clog2(MIN_GAP + 2);
  localparam logic [RISE_W-1:0] RISE_LAST = RISE_W'(CONV_CLKS - 1);
  localparam logic [GAP_W-1:0]  GAP_MIN   = GAP_W'(MIN_GAP);

  // Frame loaded at start: flag then sample, or all zeros when not ready.
  function automatic logic [FRAME_W-1:0] frame_word(input logic rdy, input logic [DATA_W-1:0] s);
    return rdy ? {1'b1, s} : '0;
  endfunction

  logic               busy_q, oe_q, sdo_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [RISE_W-1:0]  rise_q;
  logic [GAP_W-1:0]   gap_q;

  logic start_evt, early_skip, counted, done_evt;

  assign start_evt  = conv_rise_i & start_ok_i & ~busy_q;
  assign early_skip = busy_q & sclk_rise_i & (rise_q == '0) & (gap_q < GAP_MIN);
  assign counted    = busy_q & sclk_rise_i & ~early_skip;
  assign done_evt   = counted & (rise_q == RISE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
      shreg_q <= '0;
      rise_q  <= '0;
      gap_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
      rise_q <= '0;
    end else if (start_evt) begin
      busy_q  <= 1'b1;
      shreg_q <= frame_word(ready_i, sample_i);
      rise_q  <= '0;
      gap_q   <= '0;
    end else begin
      if (busy_q && gap_q < GAP_MIN) gap_q <= gap_q + GAP_W'(1);
      if (done_evt) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
        sdo_q  <= 1'b0;
        rise_q <= '0;
      end else if (counted) begin
        rise_q  <= rise_q + RISE_W'(1);
        oe_q    <= 1'b1;
        sdo_q   <= shreg_q[FRAME_W-1];
        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_o  = sdo_q;
  assign oe_o   = oe_q;
  assign busy_o = busy_q;

  assert_hiz_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!oe_q && !sdo_q));

  assert_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && conv_rise_i && !sclk_rise_i && !abort_i) |=> ($stable(rise_q) && $stable(shreg_q) && busy_q));

  assert_hold_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !counted && !abort_i) |=> $stable(shreg_q));

  assert_zero_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !abort_i && !ready_i) |=> (shreg_q == '0));

  assert_early_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (early_skip && !abort_i) |=> (rise_q == '0 && !oe_q && busy_q));

  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (counted && rise_q == '0 && !abort_i) |=> oe_q);

  assert_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy_q && !oe_q));

endmodule

// File: rtl/serial_adc_responder.sv
module serial_adc_responder
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned CONV_CLKS     = 16,
  parameter int unsigned MIN_GAP       = 4,
  parameter int unsigned SETTLE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              conv_in,
  input  logic [DATA_W-1:0] smp_in,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int unsigned N_EDGES = 3;
  // Edge taps: 0 = serial clock rise, 1 = convert rise, 2 = convert fall.
  localparam bit [N_EDGES-1:0] TAP_RISING = 3'b011;

  logic [N_EDGES-1:0] tap_src, tap_evt;
  assign tap_src = {conv_in, conv_in, sclk_in};

  for (genvar gi = 0; gi < N_EDGES; gi++) begin : g_tap
    sadc_edge #(.RISING(TAP_RISING[gi])) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (tap_src[gi]),
      .edge_o (tap_evt[gi])
    );
  end

  logic     sclk_rise, conv_rise, conv_fall;
  pm_mode_e mode;
  logic     ready, sleep_evt, busy, start_ok;

  assign sclk_rise = tap_evt[0];
  assign conv_rise = tap_evt[1];
  assign conv_fall = tap_evt[2];
  assign start_ok  = mode_accepts_start(mode);

  sadc_power #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_power (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_lvl_i  (sclk_in),
    .sclk_rise_i (sclk_rise),
    .conv_fall_i (conv_fall),
    .mode_o      (mode),
    .ready_o     (ready),
    .sleep_evt_o (sleep_evt)
  );

  sadc_shift #(
    .DATA_W    (DATA_W),
    .CONV_CLKS (CONV_CLKS),
    .MIN_GAP   (MIN_GAP)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ok_i  (start_ok),
    .ready_i     (ready),
    .conv_rise_i (conv_rise),
    .sclk_rise_i (sclk_rise),
    .abort_i     (sleep_evt),
    .sample_i    (smp_in),
    .sdo_o       (sdo),
    .oe_o        (sdo_oe),
    .busy_o      (busy)
  );

  assert_sleep_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_LIGHT || mode == PM_DEEP) |-> (!busy && !sdo_oe));

  assert_sleep_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == PM_LIGHT || mode == PM_DEEP) && conv_rise) |=> !busy);

endmodule

// File: tb/serial_adc_responder_bench.sv
module serial_adc_responder_bench;

  localparam int DW     = 12;
  localparam int SETTLE = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic          conv = 1'b0;
  logic [DW-1:0] smp = '0;
  logic          sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_adc_responder #(.DATA_W(DW), .SETTLE_CYCLES(SETTLE)) u_serial_adc_responder (
    .clk (clk), .rst_n (rst_n), .sclk_in (sclk), .conv_in (conv),
    .smp_in (smp), .sdo (sdo), .sdo_oe (sdo_oe)
  );

  // Bit 12 = take the first serial edge too soon after convert; bits 11:0 = sample.
  localparam logic [12:0] VECS [0:5] = '{
    13'h0ABC, 13'h0FFF, 13'h1000, 13'h1A5A, 13'h0801, 13'h1001
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sclk_pulse(output logic o, output logic d);
    sclk = 1'b1;
    tick(1);
    o = sdo_oe;
    d = sdo;
    tick(1);
    sclk = 1'b0;
    tick(2);
  endtask

  task automatic conv_pulse();
    conv = 1'b1; tick(2);
    conv = 1'b0; tick(2);
  endtask

  task automatic run_frame(input logic [DW-1:0] s, input bit early, input bit rdy, input string req);
    logic o, d;
    logic [DW:0] word;
    word = rdy ? {1'b1, s} : '0;
    smp  = s;
    conv = 1'b1;
    tick(1);
    if (!early) begin
      tick(1); conv = 1'b0; tick(4);
    end
    for (int i = 0; i < 16 + int'(early); i++) begin
      int j;
      bit exp_o, exp_d;
      sclk_pulse(o, d);
      if (i == 0) conv = 1'b0;
      if (i == 3) smp = ~s;                 // R5: late sample change
      if (i == 5) begin                      // R1: stray convert pulse mid-frame
        conv = 1'b1; tick(1); conv = 1'b0; tick(1);
      end
      j = i - int'(early);
      exp_o = (j >= 0) && (j < 15);
      exp_d = (j >= 0 && j <= 12) ? word[12-j] : 1'b0;
      if (early && i == 0) check(o == 1'b0, "R4", int'(o), 0);
      else                 check(o == exp_o, "R2", int'(o), int'(exp_o));
      check(d == exp_d, req, int'(d), int'(exp_d));
    end
    tick(2);
  endtask

  task automatic wake_idle(input string req);
    logic o, d;
    for (int i = 0; i < 16; i++) begin
      sclk_pulse(o, d);
      check(o == 1'b0 && d == 1'b0, req, int'(o), 0);
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R12 / R3: idle after reset
    check(sdo_oe == 1'b0, "R12", int'(sdo_oe), 0);
    check(sdo == 1'b0, "R3", int'(sdo), 0);

    // R12: first frame carries a set ready flag; vectors cover R2, R4, R5, R1
    foreach (VECS[k]) run_frame(VECS[k][11:0], VECS[k][12], 1'b1, "R2 R5");

    // R6 + R8: three pulses with clock low -> light sleep, frame abandoned
    conv_pulse(); conv_pulse(); conv_pulse();
    check(sdo_oe == 1'b0, "R6", int'(sdo_oe), 0);
    wake_idle("R6");
    // R9: awake again with ready flag still set
    run_frame(12'h3C5, 1'b0, 1'b1, "R9");

    // R7: four pulses -> deep sleep; R10: wake enters settling
    conv_pulse(); conv_pulse(); conv_pulse(); conv_pulse();
    wake_idle("R7");
    // R11: conversion during settling is all zeros
    run_frame(12'hFFF, 1'b0, 1'b0, "R11");
    tick(SETTLE + 50);
    // R10: after settling the ready flag is set again
    run_frame(12'h5A3, 1'b0, 1'b1, "R10");

    // R8: a single pulse then clock is just an ordinary frame
    run_frame(12'h00F, 1'b1, 1'b1, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule